// File: doc/BRIEF.md
# Boundary-Scan Vector Concatenation Controller

This block sits in front of a JTAG master and builds complete scan-chain vectors for a chain of boundary-scan devices while the test runs. Only one set of stimulus/expected-response pairs is stored per device type. A per-device description (type, instruction length, data length, pass-through and internal-test opcodes) is presented on flat input ports, and a command gives a mask of the devices to test. The block first scans one combined instruction that puts every selected device into internal test and every other device into pass-through. It then loops over patterns. For each pattern it shifts in the combined stimulus vector, pulses an apply strobe, and shifts out the combined response vector. Each selected device's slice of the response is compared against the expected response for that device's type.

The serial stream leaves the block one bit per cycle on a valid/bit/flag interface: `sh_ir` tells the master which scan it belongs to, and `sh_last` marks the bit on which to leave the shift state. The master returns the response bit on `sh_tdo` in the same cycle. Pattern data comes from a synchronous read port that is shared by all types. Because devices of the same type read the same entry, the stored data is shared between them. One sticky fail flag is kept per device, and a one-cycle done pulse closes the run.

Top module: `scan_concat`

## Requirements
- R1: The instruction scan visits devices from index `chain_n-1` down to 0 with `sh_ir`=1, sending each device's internal-test opcode if it is selected and its pass-through opcode otherwise, least significant bit first, for exactly that device's instruction length.
- R2: In the stimulus pass of pattern p, devices are visited in the same descending order with `sh_ir`=0. A selected device with p below its type's pattern count sends its type's stimulus p, LSB first, for its data length. A selected device whose type has run out of patterns sends that many zeros. An unselected device sends one 0 bit.
- R3: A device that is selected and still has patterns raises `pat_rd` for one cycle with its type on `pat_type` and the pattern index on `pat_idx`, and consumes `pat_stim`/`pat_exp` in the following cycle. It does so once in the stimulus pass and once in the response pass.
- R4: One `apply` pulse separates the stimulus pass from the response pass of each pattern. The response pass has the same layout as the stimulus pass, with `sh_tdi`=0 throughout.
- R5: In the response pass, `sh_tdo` is compared bit for bit (LSB first) against the type's expected response, only for devices that are selected and still have patterns. Pass-through bits and bits of devices that have run out of patterns never set a fail flag.
- R6: `dev_fail[d]` clears when a command is accepted, is set by any mismatch of device d, and holds until the next command.
- R7: The number of patterns in a run equals the largest pattern count among the selected types. With no device selected, the run ends right after the instruction scan.
- R8: Every device segment takes 2 cycles plus its shifted length. Counting the cycle after the accepting edge as cycle 0, `done` is high for exactly one cycle at T = sum over devices of (2 + IR length) + P·(2·S + 1), where S = sum over devices of (2 + segment length) and P is the pattern count. `busy` is high from cycle 0 through cycle T and low afterwards.
- R9: `sh_last` is high on the final bit of each instruction scan and of each stimulus or response pass, and on no other bit.
- R10: `cmd_start` is ignored while `busy` is high. The running select mask, stream and timing are unaffected.
- R11: After reset, `busy`, `done`, `apply`, `sh_valid`, `pat_rd` and `dev_fail` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_start | input | 1 | Starts a run when idle |
| cmd_sel | input | NDEV | Devices to test, bit d for device d |
| chain_n | input | $clog2(NDEV+1) | Number of devices on the chain (1..NDEV) |
| dev_type | input | NDEV·TW | Type of each device |
| dev_ir_len | input | NDEV·$clog2(IRW+1) | Instruction length of each device |
| dev_dr_len | input | NDEV·$clog2(DRW+1) | Test data length of each device |
| dev_byp_op | input | NDEV·IRW | Pass-through opcode of each device |
| dev_int_op | input | NDEV·IRW | Internal-test opcode of each device |
| type_npat | input | NTYPE·PATW | Pattern count of each type |
| pat_rd | output | 1 | Pattern read strobe |
| pat_type | output | TW | Type being read |
| pat_idx | output | PATW | Pattern index being read |
| pat_stim | input | DRW | Stimulus, valid the cycle after `pat_rd` |
| pat_exp | input | DRW | Expected response, valid the cycle after `pat_rd` |
| sh_valid | output | 1 | A scan bit is presented this cycle |
| sh_ir | output | 1 | The bit belongs to the instruction scan |
| sh_tdi | output | 1 | Bit to shift into the chain |
| sh_last | output | 1 | Final bit of the current scan or pass |
| sh_tdo | input | 1 | Bit shifted out of the chain, same cycle |
| apply | output | 1 | Apply the stimulus just shifted |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| dev_fail | output | NDEV | Sticky per-device mismatch flags |

## Verification
Each stream bit is due in the same cycle as its `sh_valid`. The bench samples at the falling edge of that cycle and answers `sh_tdo` before the next rising edge, so the design captures the bit at the end of that cycle. Stored data is returned one cycle after `pat_rd`, as a registered read model would deliver it. `done` is checked against the cycle number T computed from the lengths and pattern counts, counted from the first falling edge after the accepting edge. `dev_fail` is read in the done cycle, and `busy` is checked one cycle later. Every select mask of a four-device chain with two types is run in three fault scenarios, one of them a fault that lands on a pattern index a type has already exhausted.

// File: rtl/scan_concat_pkg.sv
package scan_concat_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEG,
    ST_LOAD,
    ST_SHIFT,
    ST_APPLY,
    ST_DONE
  } sc_state_e;

  typedef enum logic [1:0] {
    PH_IR,
    PH_IN,
    PH_OUT
  } sc_phase_e;

endpackage

// File: rtl/scan_concat_desc.sv
module scan_concat_desc #(
  parameter int NDEV  = 8,
  parameter int NTYPE = 4,
  parameter int IRW   = 16,
  parameter int DRW   = 64,
  parameter int PATW  = 8,
  localparam int IW   = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int TW   = (NTYPE > 1) ? $clog2(NTYPE) : 1,
  localparam int IRLW = $clog2(IRW + 1),
  localparam int DRLW = $clog2(DRW + 1)
) (
  input  logic [IW-1:0]         dev_idx,
  input  logic [NDEV-1:0]       sel,
  input  logic [NDEV*TW-1:0]    dev_type,
  input  logic [NDEV*IRLW-1:0]  dev_ir_len,
  input  logic [NDEV*DRLW-1:0]  dev_dr_len,
  input  logic [NDEV*IRW-1:0]   dev_byp_op,
  input  logic [NDEV*IRW-1:0]   dev_int_op,
  input  logic [NTYPE*PATW-1:0] type_npat,
  output logic [TW-1:0]         cur_type,
  output logic [IRLW-1:0]       cur_ir_len,
  output logic [DRLW-1:0]       cur_dr_len,
  output logic [IRW-1:0]        cur_byp,
  output logic [IRW-1:0]        cur_int,
  output logic [PATW-1:0]       cur_npat,
  output logic [PATW-1:0]       max_npat
);

  always_comb begin
    cur_type   = dev_type[dev_idx*TW +: TW];
    cur_ir_len = dev_ir_len[dev_idx*IRLW +: IRLW];
    cur_dr_len = dev_dr_len[dev_idx*DRLW +: DRLW];
    cur_byp    = dev_byp_op[dev_idx*IRW +: IRW];
    cur_int    = dev_int_op[dev_idx*IRW +: IRW];
    cur_npat   = type_npat[cur_type*PATW +: PATW];
  end

  // Largest pattern count among the selected devices' types.
  always_comb begin
    logic [TW-1:0]   t;
    logic [PATW-1:0] n;
    max_npat = '0;
    for (int i = 0; i < NDEV; i++) begin
      t = dev_type[i*TW +: TW];
      n = type_npat[t*PATW +: PATW];
      if (sel[i] && (n > max_npat)) max_npat = n;
    end
  end

endmodule

// File: rtl/scan_concat_shift.sv
module scan_concat_shift #(
  parameter int SW = 64,
  localparam int CW = $clog2(SW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] load_val,
  input  logic [SW-1:0] load_exp,
  input  logic [CW-1:0] load_len,
  input  logic          step,
  output logic          bit_out,
  output logic          exp_bit,
  output logic          seg_last
);

  logic [SW-1:0] val_q, val_d;
  logic [SW-1:0] exp_q, exp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    en    = load | step;
    val_d = val_q;
    exp_d = exp_q;
    cnt_d = cnt_q;
    if (load) begin
      val_d = load_val;
      exp_d = load_exp;
      cnt_d = load_len;
    end else if (step) begin
      val_d = val_q >> 1;
      exp_d = exp_q >> 1;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      exp_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      val_q <= val_d;
      exp_q <= exp_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_out  = val_q[0];
  assign exp_bit  = exp_q[0];
  assign seg_last = (cnt_q == CW'(1));

endmodule

// File: rtl/scan_concat_fail.sv
module scan_concat_fail #(
  parameter int NDEV = 8,
  localparam int IW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cmp_en,
  input  logic [IW-1:0]   idx,
  input  logic            mismatch,
  output logic [NDEV-1:0] fail
);

  for (genvar g = 0; g < NDEV; g++) begin : g_flag
    logic hit;
    logic flag_d;
    logic flag_q;
    logic en;

    always_comb begin
      hit    = cmp_en && mismatch && (idx == IW'(g));
      en     = clr | hit;
      flag_d = clr ? 1'b0 : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q <= 1'b0;
      else if (en) flag_q <= flag_d;
    end

    assign fail[g] = flag_q;
  end

endmodule

// File: rtl/scan_concat.sv
module scan_concat
  import scan_concat_pkg::*;
#(
  parameter int NDEV  = 8,
  parameter int NTYPE = 4,
  parameter int IRW   = 16,
  parameter int DRW   = 64,
  parameter int PATW  = 8,
  localparam int IW   = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int TW   = (NTYPE > 1) ? $clog2(NTYPE) : 1,
  localparam int IRLW = $clog2(IRW + 1),
  localparam int DRLW = $clog2(DRW + 1),
  localparam int NW   = $clog2(NDEV + 1),
  localparam int SW   = (DRW > IRW) ? DRW : IRW,
  localparam int CW   = $clog2(SW + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_start,
  input  logic [NDEV-1:0]       cmd_sel,
  input  logic [NW-1:0]         chain_n,
  input  logic [NDEV*TW-1:0]    dev_type,
  input  logic [NDEV*IRLW-1:0]  dev_ir_len,
  input  logic [NDEV*DRLW-1:0]  dev_dr_len,
  input  logic [NDEV*IRW-1:0]   dev_byp_op,
  input  logic [NDEV*IRW-1:0]   dev_int_op,
  input  logic [NTYPE*PATW-1:0] type_npat,
  output logic                  pat_rd,
  output logic [TW-1:0]         pat_type,
  output logic [PATW-1:0]       pat_idx,
  input  logic [DRW-1:0]        pat_stim,
  input  logic [DRW-1:0]        pat_exp,
  output logic                  sh_valid,
  output logic                  sh_ir,
  output logic                  sh_tdi,
  output logic                  sh_last,
  input  logic                  sh_tdo,
  output logic                  apply,
  output logic                  busy,
  output logic                  done,
  output logic [NDEV-1:0]       dev_fail
);

  sc_state_e       state_q, state_d;
  sc_phase_e       phase_q, phase_d;
  logic [IW-1:0]   dev_q, dev_d;
  logic [IW-1:0]   nlast_q, nlast_d;
  logic [PATW-1:0] pat_q, pat_d;
  logic [NDEV-1:0] sel_q, sel_d;
  logic            cmp_q, cmp_d;

  logic [TW-1:0]   cur_type;
  logic [IRLW-1:0] cur_ir_len;
  logic [DRLW-1:0] cur_dr_len;
  logic [IRW-1:0]  cur_byp;
  logic [IRW-1:0]  cur_int;
  logic [PATW-1:0] cur_npat;
  logic [PATW-1:0] max_npat;

  logic            ld, step;
  logic [SW-1:0]   ld_val, ld_exp;
  logic [CW-1:0]   ld_len;
  logic            bit_o, exp_o, seg_last;

  logic            accept;
  logic            act;
  logic [NDEV-1:0] present;

  scan_concat_desc #(
    .NDEV(NDEV), .NTYPE(NTYPE), .IRW(IRW), .DRW(DRW), .PATW(PATW)
  ) i_desc (
    .dev_idx    (dev_q),
    .sel        (sel_q),
    .dev_type   (dev_type),
    .dev_ir_len (dev_ir_len),
    .dev_dr_len (dev_dr_len),
    .dev_byp_op (dev_byp_op),
    .dev_int_op (dev_int_op),
    .type_npat  (type_npat),
    .cur_type   (cur_type),
    .cur_ir_len (cur_ir_len),
    .cur_dr_len (cur_dr_len),
    .cur_byp    (cur_byp),
    .cur_int    (cur_int),
    .cur_npat   (cur_npat),
    .max_npat   (max_npat)
  );

  scan_concat_shift #(.SW(SW)) i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .load_exp (ld_exp),
    .load_len (ld_len),
    .step     (step),
    .bit_out  (bit_o),
    .exp_bit  (exp_o),
    .seg_last (seg_last)
  );

  scan_concat_fail #(.NDEV(NDEV)) i_fail (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .cmp_en   (sh_valid && cmp_q),
    .idx      (dev_q),
    .mismatch (sh_tdo ^ exp_o),
    .fail     (dev_fail)
  );

  always_comb begin
    for (int i = 0; i < NDEV; i++) present[i] = (NW'(i) < chain_n);
  end

  assign accept = (state_q == ST_IDLE) && cmd_start;
  assign act    = sel_q[dev_q] && (pat_q < cur_npat);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    dev_d   = dev_q;
    nlast_d = nlast_q;
    pat_d   = pat_q;
    sel_d   = sel_q;
    cmp_d   = cmp_q;
    pat_rd  = 1'b0;
    ld      = 1'b0;
    step    = 1'b0;
    ld_val  = '0;
    ld_exp  = '0;
    ld_len  = '0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_start) begin
          sel_d   = cmd_sel & present;
          nlast_d = IW'(chain_n - 1'b1);
          dev_d   = IW'(chain_n - 1'b1);
          phase_d = PH_IR;
          pat_d   = '0;
          state_d = ST_SEG;
        end
      end
      ST_SEG: begin
        pat_rd  = (phase_q != PH_IR) && act;
        state_d = ST_LOAD;
      end
      ST_LOAD: begin
        ld = 1'b1;
        if (phase_q == PH_IR) begin
          ld_val = SW'(sel_q[dev_q] ? cur_int : cur_byp);
          ld_len = CW'(cur_ir_len);
          cmp_d  = 1'b0;
        end else begin
          ld_val = ((phase_q == PH_IN) && act) ? SW'(pat_stim) : '0;
          ld_exp = SW'(pat_exp);
          ld_len = sel_q[dev_q] ? CW'(cur_dr_len) : CW'(1);
          cmp_d  = (phase_q == PH_OUT) && act;
        end
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        step = 1'b1;
        if (seg_last) begin
          if (dev_q != '0) begin
            dev_d   = dev_q - 1'b1;
            state_d = ST_SEG;
          end else begin
            case (phase_q)
              PH_IR: begin
                if (max_npat == '0) begin
                  state_d = ST_DONE;
                end else begin
                  phase_d = PH_IN;
                  dev_d   = nlast_q;
                  state_d = ST_SEG;
                end
              end
              PH_IN:   state_d = ST_APPLY;
              default: begin
                if (({1'b0, pat_q} + 1'b1) >= {1'b0, max_npat}) begin
                  state_d = ST_DONE;
                end else begin
                  pat_d   = pat_q + 1'b1;
                  phase_d = PH_IN;
                  dev_d   = nlast_q;
                  state_d = ST_SEG;
                end
              end
            endcase
          end
        end
      end
      ST_APPLY: begin
        phase_d = PH_OUT;
        dev_d   = nlast_q;
        state_d = ST_SEG;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_IR;
      dev_q   <= '0;
      nlast_q <= '0;
      pat_q   <= '0;
      sel_q   <= '0;
      cmp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      dev_q   <= dev_d;
      nlast_q <= nlast_d;
      pat_q   <= pat_d;
      sel_q   <= sel_d;
      cmp_q   <= cmp_d;
    end
  end

  assign sh_valid = (state_q == ST_SHIFT);
  assign sh_ir    = sh_valid && (phase_q == PH_IR);
  assign sh_tdi   = sh_valid && bit_o;
  assign sh_last  = sh_valid && seg_last && (dev_q == '0);
  assign apply    = (state_q == ST_APPLY);
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign pat_type = cur_type;
  assign pat_idx  = pat_q;

endmodule

// File: rtl/scan_concat_chk.sv
module scan_concat_chk #(
  parameter int NDEV = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_start,
  input logic            busy,
  input logic            done,
  input logic            apply,
  input logic            sh_valid,
  input logic            sh_last,
  input logic            pat_rd,
  input logic [NDEV-1:0] dev_fail
);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r4_apply_single: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !apply);

  a_r4_apply_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> (!sh_valid && !pat_rd));

  a_r9_last_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    sh_last |-> sh_valid);

  a_r8_activity_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid || apply || pat_rd || done) |-> busy);

  a_r3_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rd |=> (!sh_valid && !pat_rd));

  a_r6_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_start) |=> $stable(dev_fail));

endmodule

bind scan_concat scan_concat_chk #(.NDEV(NDEV)) i_scan_concat_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .busy      (busy),
  .done      (done),
  .apply     (apply),
  .sh_valid  (sh_valid),
  .sh_last   (sh_last),
  .pat_rd    (pat_rd),
  .dev_fail  (dev_fail)
);

// File: tb/test_scan_concat.sv
module test_scan_concat;

  localparam int NDEV  = 4;
  localparam int NTYPE = 2;
  localparam int IRW   = 4;
  localparam int DRW   = 8;
  localparam int PATW  = 4;
  localparam int TW    = 1;
  localparam int IRLW  = $clog2(IRW + 1);
  localparam int DRLW  = $clog2(DRW + 1);
  localparam int NW    = $clog2(NDEV + 1);
  localparam int MAXB  = 512;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                  rst_n;
  logic                  cmd_start;
  logic [NDEV-1:0]       cmd_sel;
  logic [NW-1:0]         chain_n;
  logic [NDEV*TW-1:0]    dev_type;
  logic [NDEV*IRLW-1:0]  dev_ir_len;
  logic [NDEV*DRLW-1:0]  dev_dr_len;
  logic [NDEV*IRW-1:0]   dev_byp_op;
  logic [NDEV*IRW-1:0]   dev_int_op;
  logic [NTYPE*PATW-1:0] type_npat;
  logic                  pat_rd;
  logic [TW-1:0]         pat_type;
  logic [PATW-1:0]       pat_idx;
  logic [DRW-1:0]        pat_stim;
  logic [DRW-1:0]        pat_exp;
  logic                  sh_valid, sh_ir, sh_tdi, sh_last, sh_tdo;
  logic                  apply, busy, done;
  logic [NDEV-1:0]       dev_fail;

  scan_concat #(
    .NDEV(NDEV), .NTYPE(NTYPE), .IRW(IRW), .DRW(DRW), .PATW(PATW)
  ) i_scan_concat (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_sel(cmd_sel),
    .chain_n(chain_n), .dev_type(dev_type), .dev_ir_len(dev_ir_len),
    .dev_dr_len(dev_dr_len), .dev_byp_op(dev_byp_op), .dev_int_op(dev_int_op),
    .type_npat(type_npat), .pat_rd(pat_rd), .pat_type(pat_type),
    .pat_idx(pat_idx), .pat_stim(pat_stim), .pat_exp(pat_exp),
    .sh_valid(sh_valid), .sh_ir(sh_ir), .sh_tdi(sh_tdi), .sh_last(sh_last),
    .sh_tdo(sh_tdo), .apply(apply), .busy(busy), .done(done),
    .dev_fail(dev_fail)
  );

  // Chain: device 0 type 0, devices 1 and 2 type 1, device 3 type 0.
  function automatic int ty(int d);   return (d == 1 || d == 2) ? 1 : 0; endfunction
  function automatic int irl(int t);  return (t == 0) ? 4 : 3; endfunction
  function automatic int drl(int t);  return (t == 0) ? 6 : 5; endfunction
  function automatic int npf(int t);  return (t == 0) ? 3 : 2; endfunction
  function automatic logic [3:0] iop(int t); return (t == 0) ? 4'b0011 : 4'b0001; endfunction
  function automatic logic [3:0] bop(int t); return (t == 0) ? 4'b1111 : 4'b0111; endfunction
  function automatic logic [7:0] stim_f(int t, int i); return 8'(i * 29 + t * 83 + 17); endfunction
  function automatic logic [7:0] exp_f(int t, int i);  return stim_f(t, i) ^ 8'h5A; endfunction

  // Registered pattern read model: data one cycle after the strobe.
  always @(posedge clk) begin
    if (pat_rd) begin
      pat_stim <= stim_f(int'(pat_type), int'(pat_idx));
      pat_exp  <= exp_f(int'(pat_type), int'(pat_idx));
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  bit         e_ir [MAXB];
  bit         e_out[MAXB];
  bit         e_tdi[MAXB];
  bit         e_tdo[MAXB];
  bit         e_last[MAXB];
  int         e_n, e_T, e_apply;
  logic [3:0] e_fail;
  int         r_t[64];
  int         r_i[64];
  int         r_n;

  task automatic push(input bit ir, input bit outp, input bit tdi,
                      input bit tdo, input bit last);
    e_ir[e_n] = ir; e_out[e_n] = outp; e_tdi[e_n] = tdi;
    e_tdo[e_n] = tdo; e_last[e_n] = last;
    e_n++;
  endtask

  task automatic build(input logic [3:0] m, input logic [3:0] fm, input int fp);
    int maxp = 0;
    int s = 0;
    logic [3:0] op;
    e_n = 0; r_n = 0; e_T = 0; e_fail = '0;
    for (int d = 3; d >= 0; d--) begin
      op = m[d] ? iop(ty(d)) : bop(ty(d));
      e_T += 2 + irl(ty(d));
      for (int k = 0; k < irl(ty(d)); k++)
        push(1'b1, 1'b0, op[k], 1'b0, (d == 0) && (k == irl(ty(d)) - 1));
    end
    for (int d = 0; d < 4; d++) begin
      if (m[d] && npf(ty(d)) > maxp) maxp = npf(ty(d));
      s += 2 + (m[d] ? drl(ty(d)) : 1);
      if (m[d] && fm[d] && fp < npf(ty(d))) e_fail[d] = 1'b1;
    end
    e_T += maxp * (2 * s + 1);
    e_apply = maxp;
    for (int p = 0; p < maxp; p++) begin
      for (int pass = 0; pass < 2; pass++) begin
        for (int d = 3; d >= 0; d--) begin
          bit act;
          int len;
          logic [7:0] sv, xv;
          act = m[d] && (p < npf(ty(d)));
          len = m[d] ? drl(ty(d)) : 1;
          sv = stim_f(ty(d), p);
          xv = exp_f(ty(d), p);
          if (act) begin r_t[r_n] = ty(d); r_i[r_n] = p; r_n++; end
          for (int k = 0; k < len; k++) begin
            bit tdi, tdo;
            tdi = (pass == 0 && act) ? sv[k] : 1'b0;
            if (pass == 0) tdo = 1'b0;
            else if (act)  tdo = xv[k] ^ (fm[d] && p == fp && k == 0);
            else           tdo = 1'b1;
            push(1'b0, pass == 1, tdi, tdo, (d == 0) && (k == len - 1));
          end
        end
      end
    end
  endtask

  task automatic run(input logic [3:0] m, input logic [3:0] fm, input int fp,
                     input bit interfere);
    int cyc = 0, pos = 0, rpos = 0, done_cyc = -1, napply = 0;
    int ir_bad = 0, in_bad = 0, out_bad = 0, last_bad = 0, rd_bad = 0, flag_bad = 0;
    bit got_done = 0, busy_ok = 1;
    logic [NDEV-1:0] fail_seen = '0;
    string tg;
    tg = interfere ? "R10" : "R8";
    build(m, fm, fp);
    @(negedge clk);
    cmd_sel = m; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    while (!got_done && cyc < 3000) begin
      if (interfere && cyc == 5) begin cmd_start = 1'b1; cmd_sel = ~m; end
      else cmd_start = 1'b0;
      if (!busy) busy_ok = 0;
      sh_tdo = 1'b0;
      if (sh_valid) begin
        if (pos < e_n) begin
          if (sh_ir != e_ir[pos]) flag_bad++;
          if (sh_tdi != e_tdi[pos]) begin
            if (e_ir[pos]) ir_bad++;
            else if (e_out[pos]) out_bad++;
            else in_bad++;
          end
          if (sh_last != e_last[pos]) last_bad++;
          sh_tdo = e_tdo[pos];
        end
        pos++;
      end
      if (pat_rd) begin
        if (rpos >= r_n || int'(pat_type) != r_t[rpos] || int'(pat_idx) != r_i[rpos])
          rd_bad++;
        rpos++;
      end
      if (apply) napply++;
      if (done) begin
        got_done = 1; done_cyc = cyc; fail_seen = dev_fail;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    cmd_start = 1'b0;
    sh_tdo = 1'b0;
    chk(got_done, tg, "run finished (watchdog)", got_done, 1);
    chk(done_cyc == e_T, tg, "done cycle", done_cyc, e_T);
    chk(busy_ok, "R8", "busy held through run", busy_ok, 1);
    chk(ir_bad == 0 && flag_bad == 0, "R1", "instruction scan bits", ir_bad + flag_bad, 0);
    chk(in_bad == 0 && pos == e_n, "R2", "stimulus bits / stream length", pos, e_n);
    chk(out_bad == 0, "R4", "tdi zero in response pass", out_bad, 0);
    chk(napply == e_apply, "R4", "apply pulses", napply, e_apply);
    chk(napply == e_apply, "R7", "pattern count of run", napply, e_apply);
    chk(rd_bad == 0 && rpos == r_n, "R3", "pattern reads", rpos, r_n);
    chk(last_bad == 0, "R9", "last-bit flags", last_bad, 0);
    chk(fail_seen == e_fail, interfere ? "R10" : "R5", "fail flags at done",
        fail_seen, e_fail);
    @(negedge clk);
    chk(!busy && !done, "R8", "idle after done", {busy, done}, 0);
    chk(dev_fail == e_fail, "R6", "fail flags held", dev_fail, e_fail);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_sel = '0; sh_tdo = 1'b0;
    chain_n = NW'(4); type_npat = '0;
    for (int d = 0; d < NDEV; d++) begin
      dev_type[d*TW +: TW]       = TW'(ty(d));
      dev_ir_len[d*IRLW +: IRLW] = IRLW'(irl(ty(d)));
      dev_dr_len[d*DRLW +: DRLW] = DRLW'(drl(ty(d)));
      dev_byp_op[d*IRW +: IRW]   = bop(ty(d));
      dev_int_op[d*IRW +: IRW]   = iop(ty(d));
    end
    for (int t = 0; t < NTYPE; t++) type_npat[t*PATW +: PATW] = PATW'(npf(t));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !apply && !sh_valid && !pat_rd && dev_fail == '0,
        "R11", "reset state", {busy, done, apply, sh_valid, pat_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 16; m++) begin
      run(4'(m), 4'b1010, 0, 1'b0);
      run(4'(m), 4'b1111, 2, 1'b0);
      run(4'(m), 4'b0000, 0, 1'b0);
    end
    run(4'b1001, 4'b0001, 0, 1'b1);
    run(4'b0110, 4'b0100, 1, 1'b1);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule